// File: doc/BRIEF.md
# SDRAM Command Legality Monitor

This block watches the command pins of a synchronous DRAM interface. On every rising clock edge it decodes the command and keeps a model of each bank's state, with one down-counter per bank. It also keeps one device-wide lock counter. Any command that would cut into a timed transition is flagged: a bank opening a row, a bank closing its row, a bank that is auto-closing after an access, a refresh, a mode-register load, or a close of all banks. Any command that the state model does not allow is flagged as well.

The monitor only observes the bus. Its outputs are the modelled state of every bank, a flag that is high when the whole device is quiescent, and a sticky violation flag with a code. The code tells a test environment or an on-chip debug block why the first bad command was rejected. A command found illegal is not applied to the model. The counters that are already running carry on, so later commands are still judged against true timing.

Top module: `sdram_cmd_guard`

## Requirements
- R1: With `cs_n_i` high the edge carries an inhibit. With `cs_n_i` low, `{ras_n_i,cas_n_i,we_n_i}` encodes the command: 000 mode load, 001 refresh, 010 precharge, 011 activate, 100 write, 101 read, 110 burst stop, 111 no-op. Inhibit and no-op never raise a violation.
- R2: Bank i reports its state on `bank_state_o[3i+2:3i]` with codes 0 idle, 1 opening, 2 row open, 3 closing, 4 auto-closing. After reset every bank reads 0, `all_idle_o` is 1, `viol_o` is 0 and `viol_code_o` is 0.
- R3: An activate accepted at edge k puts its bank in state 1. The bank reaches state 2 after edge k+T_RCD-1. Commands to that bank at edges k+1 through k+T_RCD-1 violate, and one at edge k+T_RCD is legal.
- R4: A precharge with `ap_i`=0 accepted at edge k puts the addressed bank in state 3 until edge k+T_RP-1. After that edge the bank is idle. This also applies when the bank was already idle.
- R5: A read or write with `ap_i`=1 to an open bank puts it in state 4 for T_AP cycles, after which it is idle. With `ap_i`=0 the bank stays in state 2.
- R6: A bank-addressed command (activate, read, write, single precharge) to a bank in state 1, 3 or 4 raises code 2. Such commands to a different, stable bank are legal.
- R7: An accepted refresh locks the device for T_RC cycles. Any command other than no-op or inhibit during the lock raises code 1, and `all_idle_o` is 0 until the lock ends.
- R8: An accepted mode load locks the device for T_MRD cycles with the same rule and code as R7.
- R9: A precharge with `ap_i`=1 is a close-all. It puts every bank in state 3 and locks the device for T_RP cycles. It raises code 2 if any bank is in state 1, 3 or 4. The device lock takes precedence, so a command during it reports code 1.
- R10: Refresh or mode load while any bank is not idle raises code 3.
- R11: An activate to an open bank, or a read or write to a bank that is not open, raises code 4.
- R12: Burst stop is checked only against the device lock, never against any bank's state, whatever bank address is driven.
- R13: The first violation sets `viol_o` and its code, and both hold until reset. Illegal commands leave the model unchanged, while running counters and later legal commands still update it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Command bus clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| ba_i | input | BA_W (2) | Bank address |
| ap_i | input | 1 | Auto-precharge / all-banks address bit |
| bank_state_o | output | 3*NUM_BANKS (12) | Packed per-bank state codes |
| all_idle_o | output | 1 | All banks idle and no device lock |
| viol_o | output | 1 | Sticky violation flag |
| viol_code_o | output | 3 | Code of the first violation |

## Verification
The bench probes each timed window at both edges. A command is sent on the last busy cycle and again on the first free one, so a counter that is off by one flags a legal command or lets an early one through. Where the device lock and a busy bank overlap, the bench checks that the code is the device-wide one. A close-all over a bank still opening is rejected, and that bank must continue to its open state; a design that applied the rejected command would show it closing instead. An inhibit carrying an activate pattern, a burst stop addressed to a busy bank, and a second fault after the first one pin down that decode ignores the chip-deselected pins and that the first code sticks.

// File: rtl/sdcg_pkg.sv
package sdcg_pkg;

    typedef enum logic [2:0] {
        CMD_LMR = 3'd0,
        CMD_REF = 3'd1,
        CMD_PRE = 3'd2,
        CMD_ACT = 3'd3,
        CMD_WR  = 3'd4,
        CMD_RD  = 3'd5,
        CMD_BT  = 3'd6,
        CMD_NOP = 3'd7
    } cmd_e;

    typedef enum logic [2:0] {
        BK_IDLE        = 3'd0,
        BK_OPENING     = 3'd1,
        BK_ROW_OPEN    = 3'd2,
        BK_CLOSING     = 3'd3,
        BK_AUTO_CLOSE  = 3'd4
    } bank_st_e;

    typedef enum logic [1:0] {
        GL_FREE    = 2'd0,
        GL_REFRESH = 2'd1,
        GL_MODE    = 2'd2,
        GL_CLOSE   = 2'd3
    } glob_e;

    typedef enum logic [2:0] {
        VC_NONE        = 3'd0,
        VC_DEVICE_BUSY = 3'd1,
        VC_BANK_BUSY   = 3'd2,
        VC_NOT_IDLE    = 3'd3,
        VC_BAD_SEQ     = 3'd4
    } viol_e;

    typedef struct packed {
        logic open;
        logic close;
        logic auto_close;
    } bank_go_t;

    function automatic logic in_transit(input bank_st_e s);
        return (s == BK_OPENING) || (s == BK_CLOSING) || (s == BK_AUTO_CLOSE);
    endfunction

    function automatic bank_st_e settle(input bank_st_e s);
        return (s == BK_OPENING) ? BK_ROW_OPEN : BK_IDLE;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdcg_decode.sv
module sdcg_decode
    import sdcg_pkg::*;
(
    input  logic cs_n_i,
    input  logic ras_n_i,
    input  logic cas_n_i,
    input  logic we_n_i,
    output cmd_e cmd_o
);
    always_comb begin
        if (cs_n_i) cmd_o = CMD_NOP;
        else        cmd_o = cmd_e'({ras_n_i, cas_n_i, we_n_i});
    end
endmodule

// File: rtl/sdcg_bank.sv
module sdcg_bank
    import sdcg_pkg::*;
#(
    parameter int CW    = 3,
    parameter int T_RCD = 3,
    parameter int T_RP  = 3,
    parameter int T_AP  = 4
) (
    input  logic     clk_i,
    input  logic     rst_i,
    input  bank_go_t go_i,
    output bank_st_e st_o
);
    bank_st_e        st_q;
    logic [CW-1:0]   cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q  <= BK_IDLE;
            cnt_q <= '0;
        end else if (go_i.open) begin
            if (T_RCD <= 1) begin
                st_q  <= BK_ROW_OPEN;
                cnt_q <= '0;
            end else begin
                st_q  <= BK_OPENING;
                cnt_q <= CW'(T_RCD - 1);
            end
        end else if (go_i.close) begin
            if (T_RP <= 1) begin
                st_q  <= BK_IDLE;
                cnt_q <= '0;
            end else begin
                st_q  <= BK_CLOSING;
                cnt_q <= CW'(T_RP - 1);
            end
        end else if (go_i.auto_close) begin
            if (T_AP <= 1) begin
                st_q  <= BK_IDLE;
                cnt_q <= '0;
            end else begin
                st_q  <= BK_AUTO_CLOSE;
                cnt_q <= CW'(T_AP - 1);
            end
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) st_q <= settle(st_q);
        end
    end

    assign st_o = st_q;
endmodule

// File: rtl/sdcg_glock.sv
module sdcg_glock
    import sdcg_pkg::*;
#(
    parameter int CW    = 3,
    parameter int T_RC  = 6,
    parameter int T_MRD = 2,
    parameter int T_RP  = 3
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic go_ref_i,
    input  logic go_mode_i,
    input  logic go_close_i,
    output logic busy_o
);
    glob_e         kind_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            kind_q <= GL_FREE;
            cnt_q  <= '0;
        end else if (go_ref_i) begin
            kind_q <= (T_RC <= 1) ? GL_FREE : GL_REFRESH;
            cnt_q  <= (T_RC <= 1) ? '0 : CW'(T_RC - 1);
        end else if (go_mode_i) begin
            kind_q <= (T_MRD <= 1) ? GL_FREE : GL_MODE;
            cnt_q  <= (T_MRD <= 1) ? '0 : CW'(T_MRD - 1);
        end else if (go_close_i) begin
            kind_q <= (T_RP <= 1) ? GL_FREE : GL_CLOSE;
            cnt_q  <= (T_RP <= 1) ? '0 : CW'(T_RP - 1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) kind_q <= GL_FREE;
        end
    end

    assign busy_o = (kind_q != GL_FREE);
endmodule

// File: rtl/sdcg_rules.sv
module sdcg_rules
    import sdcg_pkg::*;
#(
    parameter int NB   = 4,
    parameter int BA_W = 2
) (
    input  cmd_e                cmd_i,
    input  logic [BA_W-1:0]     ba_i,
    input  logic                ap_i,
    input  bank_st_e [NB-1:0]   st_i,
    input  logic                dev_busy_i,
    output viol_e               code_o
);
    bank_st_e tgt;
    logic     any_transit;
    logic     all_idle;

    always_comb begin
        any_transit = 1'b0;
        all_idle    = 1'b1;
        for (int i = 0; i < NB; i++) begin
            if (in_transit(st_i[i])) any_transit = 1'b1;
            if (st_i[i] != BK_IDLE)  all_idle    = 1'b0;
        end
    end

    assign tgt = st_i[ba_i];

    always_comb begin
        code_o = VC_NONE;
        if (cmd_i != CMD_NOP) begin
            if (dev_busy_i) begin
                code_o = VC_DEVICE_BUSY;
            end else begin
                case (cmd_i)
                    CMD_LMR, CMD_REF: begin
                        if (!all_idle) code_o = VC_NOT_IDLE;
                    end
                    CMD_PRE: begin
                        if (ap_i ? any_transit : in_transit(tgt)) code_o = VC_BANK_BUSY;
                    end
                    CMD_ACT: begin
                        if (in_transit(tgt))       code_o = VC_BANK_BUSY;
                        else if (tgt != BK_IDLE)   code_o = VC_BAD_SEQ;
                    end
                    CMD_WR, CMD_RD: begin
                        if (in_transit(tgt))          code_o = VC_BANK_BUSY;
                        else if (tgt != BK_ROW_OPEN)  code_o = VC_BAD_SEQ;
                    end
                    default: code_o = VC_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
    import sdcg_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_AP      = 4,
    parameter int T_RC      = 6,
    parameter int T_MRD     = 2,
    localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   cs_n_i,
    input  logic                   ras_n_i,
    input  logic                   cas_n_i,
    input  logic                   we_n_i,
    input  logic [BA_W-1:0]        ba_i,
    input  logic                   ap_i,
    output logic [3*NUM_BANKS-1:0] bank_state_o,
    output logic                   all_idle_o,
    output logic                   viol_o,
    output logic [2:0]             viol_code_o
);
    localparam int T_MAX = max2(max2(max2(T_RCD, T_RP), max2(T_AP, T_RC)), T_MRD);
    localparam int CW    = $clog2(T_MAX + 1);

    cmd_e                     cmd;
    viol_e                    code_now;
    logic                     cmd_legal;
    logic                     dev_busy;
    bank_st_e [NUM_BANKS-1:0] bank_st;
    viol_e                    code_q;
    logic                     viol_q;

    sdcg_decode u_dec (
        .cs_n_i (cs_n_i),
        .ras_n_i(ras_n_i),
        .cas_n_i(cas_n_i),
        .we_n_i (we_n_i),
        .cmd_o  (cmd)
    );

    sdcg_rules #(.NB(NUM_BANKS), .BA_W(BA_W)) u_rules (
        .cmd_i     (cmd),
        .ba_i      (ba_i),
        .ap_i      (ap_i),
        .st_i      (bank_st),
        .dev_busy_i(dev_busy),
        .code_o    (code_now)
    );

    assign cmd_legal = (code_now == VC_NONE);

    sdcg_glock #(.CW(CW), .T_RC(T_RC), .T_MRD(T_MRD), .T_RP(T_RP)) u_glock (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .go_ref_i  (cmd_legal && (cmd == CMD_REF)),
        .go_mode_i (cmd_legal && (cmd == CMD_LMR)),
        .go_close_i(cmd_legal && (cmd == CMD_PRE) && ap_i),
        .busy_o    (dev_busy)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        bank_go_t go;
        logic     hit;

        assign hit           = (ba_i == BA_W'(g));
        assign go.open       = cmd_legal && (cmd == CMD_ACT) && hit;
        assign go.close      = cmd_legal && (cmd == CMD_PRE) && (ap_i || hit);
        assign go.auto_close = cmd_legal && ((cmd == CMD_RD) || (cmd == CMD_WR)) && ap_i && hit;

        sdcg_bank #(.CW(CW), .T_RCD(T_RCD), .T_RP(T_RP), .T_AP(T_AP)) u_bank (
            .clk_i(clk_i),
            .rst_i(rst_i),
            .go_i (go),
            .st_o (bank_st[g])
        );

        assign bank_state_o[3*g +: 3] = bank_st[g];
    end

    always_comb begin
        all_idle_o = !dev_busy;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_st[i] != BK_IDLE) all_idle_o = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            viol_q <= 1'b0;
            code_q <= VC_NONE;
        end else if (!viol_q && !cmd_legal) begin
            viol_q <= 1'b1;
            code_q <= code_now;
        end
    end

    assign viol_o      = viol_q;
    assign viol_code_o = code_q;
endmodule

// File: rtl/sdcg_props.sv
module sdcg_props
    import sdcg_pkg::*;
#(
    parameter int NB    = 4,
    parameter int T_RCD = 3,
    parameter int T_RC  = 6
) (
    input logic              clk_i,
    input logic              rst_i,
    input cmd_e              cmd_i,
    input logic              legal_i,
    input bank_st_e [NB-1:0] st_i,
    input logic              all_idle_i,
    input logic              viol_i,
    input logic [2:0]        code_i
);
    // R13
    sticky_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        viol_i |=> (viol_i && $stable(code_i)));

    // R13
    code_nonzero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        viol_i |-> (code_i != 3'd0));

    // R1
    nop_never_flags_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (cmd_i == CMD_NOP) |-> legal_i);

    // R13
    rise_needs_cmd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(viol_i) |-> $past(cmd_i != CMD_NOP));

    if (T_RC > 1) begin : g_ref
        // R7
        refresh_lock_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            ((cmd_i == CMD_REF) && legal_i) |=> !all_idle_i);
    end

    if (T_RCD > 1) begin : g_open
        for (genvar b = 0; b < NB; b++) begin : g_b
            // R3
            open_path_chk: assert property (@(posedge clk_i) disable iff (rst_i)
                ((st_i[b] == BK_ROW_OPEN) && ($past(st_i[b]) != BK_ROW_OPEN))
                    |-> ($past(st_i[b]) == BK_OPENING));
        end
    end
endmodule

bind sdram_cmd_guard sdcg_props #(.NB(NUM_BANKS), .T_RCD(T_RCD), .T_RC(T_RC)) u_props (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .cmd_i     (cmd),
    .legal_i   (cmd_legal),
    .st_i      (bank_st),
    .all_idle_i(all_idle_o),
    .viol_i    (viol_o),
    .code_i    (viol_code_o)
);

// File: tb/sim_sdram_cmd_guard.sv
module sim_sdram_cmd_guard;
    localparam int NB = 4;
    localparam logic [2:0] C_LMR = 3'd0, C_REF = 3'd1, C_PRE = 3'd2, C_ACT = 3'd3,
                           C_WR  = 3'd4, C_RD  = 3'd5, C_BT  = 3'd6, C_NOP = 3'd7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] ba = '0;
    logic ap = 1'b0;
    logic [3*NB-1:0] st;
    logic all_idle, viol;
    logic [2:0] code;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sdram_cmd_guard #(.NUM_BANKS(NB), .T_RCD(3), .T_RP(3), .T_AP(4), .T_RC(6), .T_MRD(2)) u0 (
        .clk_i(clk), .rst_i(rst), .cs_n_i(cs_n), .ras_n_i(ras_n), .cas_n_i(cas_n),
        .we_n_i(we_n), .ba_i(ba), .ap_i(ap), .bank_state_o(st), .all_idle_o(all_idle),
        .viol_o(viol), .viol_code_o(code)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int bst(input int i);
        return int'(st[3*i +: 3]);
    endfunction

    task automatic drive(input logic [2:0] rcw, input int bank, input logic apb, input logic csn);
        cs_n = csn;
        {ras_n, cas_n, we_n} = rcw;
        ba = bank[1:0];
        ap = apb;
        @(posedge clk);
        @(negedge clk);
        cs_n = 1'b1;
        {ras_n, cas_n, we_n} = C_NOP;
        ap = 1'b0;
    endtask

    task automatic issue(input logic [2:0] rcw, input int bank, input logic apb);
        drive(rcw, bank, apb, 1'b0);
    endtask

    task automatic nops(input int n);
        for (int i = 0; i < n; i++) issue(C_NOP, 0, 1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cs_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        for (int i = 0; i < NB; i++) check("R2 reset bank state", bst(i), 0);
        check("R2 reset all_idle", int'(all_idle), 1);
        check("R2 reset viol", int'(viol), 0);
        check("R2 reset code", int'(code), 0);
    endtask

    task automatic t_open();
        do_reset();
        issue(C_ACT, 1, 1'b0);
        check("R3 opening after act", bst(1), 1);
        check("R2 all_idle low", int'(all_idle), 0);
        nops(1);
        check("R3 still opening", bst(1), 1);
        nops(1);
        check("R3 row open", bst(1), 2);
        issue(C_RD, 1, 1'b0);
        check("R5 read no ap keeps open", bst(1), 2);
        check("R3 no viol", int'(viol), 0);
    endtask

    task automatic t_open_early();
        do_reset();
        issue(C_ACT, 0, 1'b0);
        issue(C_ACT, 2, 1'b0);
        check("R6 other bank legal", int'(viol), 0);
        issue(C_RD, 0, 1'b0);
        check("R3 last busy edge viol", int'(viol), 1);
        check("R6 bank busy code", int'(code), 2);
    endtask

    task automatic t_open_edge();
        do_reset();
        issue(C_ACT, 3, 1'b0);
        nops(2);
        issue(C_WR, 3, 1'b0);
        check("R3 first free edge legal", int'(viol), 0);
        check("R3 bank open", bst(3), 2);
    endtask

    task automatic t_close();
        do_reset();
        issue(C_ACT, 0, 1'b0);
        nops(2);
        issue(C_PRE, 0, 1'b0);
        check("R4 closing", bst(0), 3);
        nops(1);
        check("R4 still closing", bst(0), 3);
        nops(1);
        check("R4 idle after tRP", bst(0), 0);
        issue(C_ACT, 0, 1'b0);
        check("R4 act after close legal", int'(viol), 0);
        do_reset();
        issue(C_PRE, 2, 1'b0);
        check("R4 precharge of idle bank", bst(2), 3);
        check("R4 no viol", int'(viol), 0);
    endtask

    task automatic t_autoclose();
        do_reset();
        issue(C_ACT, 2, 1'b0);
        nops(2);
        issue(C_RD, 2, 1'b1);
        check("R5 auto close", bst(2), 4);
        nops(2);
        check("R5 still auto close", bst(2), 4);
        nops(1);
        check("R5 idle after auto close", bst(2), 0);
        check("R5 no viol", int'(viol), 0);
    endtask

    task automatic t_refresh();
        do_reset();
        issue(C_REF, 0, 1'b0);
        check("R7 lock all_idle low", int'(all_idle), 0);
        nops(4);
        check("R7 lock still on", int'(all_idle), 0);
        nops(1);
        check("R7 lock over", int'(all_idle), 1);
        issue(C_ACT, 0, 1'b0);
        check("R7 act at tRC legal", int'(viol), 0);
        do_reset();
        issue(C_REF, 0, 1'b0);
        nops(4);
        issue(C_ACT, 0, 1'b0);
        check("R7 act in lock", int'(viol), 1);
        check("R7 device busy code", int'(code), 1);
    endtask

    task automatic t_mode();
        do_reset();
        issue(C_LMR, 0, 1'b0);
        issue(C_ACT, 1, 1'b0);
        check("R8 act in mode lock code", int'(code), 1);
        do_reset();
        issue(C_LMR, 0, 1'b0);
        nops(1);
        issue(C_ACT, 1, 1'b0);
        check("R8 act after mode lock legal", int'(viol), 0);
    endtask

    task automatic t_not_idle();
        do_reset();
        issue(C_ACT, 1, 1'b0);
        nops(2);
        issue(C_REF, 0, 1'b0);
        check("R10 refresh with open bank", int'(code), 3);
        do_reset();
        issue(C_ACT, 1, 1'b0);
        nops(2);
        issue(C_LMR, 0, 1'b0);
        check("R10 mode load with open bank", int'(code), 3);
    endtask

    task automatic t_close_all();
        do_reset();
        issue(C_ACT, 0, 1'b0);
        nops(2);
        issue(C_PRE, 0, 1'b1);
        for (int i = 0; i < NB; i++) check("R9 all closing", bst(i), 3);
        check("R9 all_idle low", int'(all_idle), 0);
        nops(2);
        for (int i = 0; i < NB; i++) check("R9 all idle after", bst(i), 0);
        check("R9 all_idle high", int'(all_idle), 1);
        check("R9 no viol", int'(viol), 0);
        do_reset();
        issue(C_ACT, 1, 1'b0);
        issue(C_PRE, 0, 1'b1);
        check("R9 close all over opening bank", int'(code), 2);
        check("R13 rejected close not applied", bst(1), 1);
        check("R13 rejected close leaves bank0", bst(0), 0);
        nops(1);
        check("R13 counter keeps running", bst(1), 2);
        do_reset();
        issue(C_PRE, 0, 1'b1);
        issue(C_ACT, 0, 1'b0);
        check("R9 device lock takes precedence", int'(code), 1);
    endtask

    task automatic t_bad_seq();
        do_reset();
        issue(C_RD, 0, 1'b0);
        check("R11 read idle bank", int'(code), 4);
        check("R13 illegal read not applied", bst(0), 0);
        issue(C_ACT, 0, 1'b0);
        check("R13 legal cmd after viol applied", bst(0), 1);
        nops(2);
        issue(C_REF, 0, 1'b0);
        check("R13 first code kept", int'(code), 4);
        check("R13 flag kept", int'(viol), 1);
        do_reset();
        issue(C_ACT, 0, 1'b0);
        nops(2);
        issue(C_ACT, 0, 1'b0);
        check("R11 act on open bank", int'(code), 4);
    endtask

    task automatic t_burst_stop();
        do_reset();
        issue(C_ACT, 1, 1'b0);
        issue(C_BT, 1, 1'b0);
        check("R12 burst stop to busy bank legal", int'(viol), 0);
        do_reset();
        issue(C_REF, 0, 1'b0);
        issue(C_BT, 0, 1'b0);
        check("R12 burst stop in lock", int'(code), 1);
    endtask

    task automatic t_inhibit();
        do_reset();
        issue(C_ACT, 0, 1'b0);
        drive(C_ACT, 0, 1'b0, 1'b1);
        check("R1 inhibit ignored", int'(viol), 0);
        issue(C_NOP, 0, 1'b0);
        check("R1 nop ignored", int'(viol), 0);
        check("R1 bank reached open", bst(0), 2);
    endtask

    initial begin
        t_reset();
        t_open();
        t_open_early();
        t_open_edge();
        t_close();
        t_autoclose();
        t_refresh();
        t_mode();
        t_not_idle();
        t_close_all();
        t_bad_seq();
        t_burst_stop();
        t_inhibit();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule